// File: doc/BRIEF.md
# Test-Mode Configuration Loader

This block sits behind the serial command decoder of a power-management chip and owns the one-time configuration of its supplies. Each decoded 16-bit command word arrives with a one-cycle valid strobe. The block watches this stream for the test-mode entry word. It accepts that word only while four strap pins show the required pattern. Once in test mode, the block accepts a single configuration-write command and stores its 8-bit payload in a shadow register. That register stands in for the one-time-programmable fuses.

The payload is committed only if it carries odd parity and has its lock bit set. After one commit the shadow register is frozen for the rest of the power cycle. Downstream logic reads the committed fields: a 4-bit supply-voltage selection, an external-divider select and a serial-bus mode select. A one-cycle accepted or rejected pulse reports the outcome of every configuration write made in test mode. While test mode is active, the block also holds the watchdog disabled.

Top module: `otp_cfg_loader`

## Requirements
- R1: Test mode is entered only when command word 0x5A5A is strobed while `pwr_good` is high and the strap pins, sampled on the previous clock edge, read `strap_in[1:0]` = 00 and `strap_in[3:2]` = 11. Any other word, or any other strap pattern, leaves test mode off.
- R2: Once entered, test mode stays set whatever the later commands or straps. It clears on the clock edge at which `pwr_good` is sampled low.
- R3: `wdg_disable` is high exactly when test mode is active.
- R4: A command whose upper byte is 0xA9, made in test mode with a valid payload, commits the payload on that edge and pulses `prog_ok` for one cycle. The payload layout is: bits [7:4] go to `cfg_vsel`, bit 3 to `cfg_ext_div`, bit 2 to `cfg_bus_mode`, bit 1 is parity and bit 0 is the lock bit. A commit also sets `cfg_locked`.
- R5: A payload with even parity over all 8 bits is discarded. It pulses `prog_rej` and leaves the configuration unchanged.
- R6: A payload with the lock bit (bit 0) clear is discarded. It pulses `prog_rej` and leaves the configuration unchanged.
- R7: After one commit the configuration is frozen. Every later 0xA9 command, even one with a valid payload, pulses `prog_rej` and changes nothing.
- R8: A 0xA9 command made outside test mode is ignored. It produces no pulse and no change to the configuration.
- R9: The configuration and `cfg_locked` clear to zero only on `rst_n`. A drop of `pwr_good` does not clear them.
- R10: `prog_ok` and `prog_rej` are single-cycle pulses that are never high together. They appear in the cycle after the command strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| pwr_good | input | 1 | Supply-good indication; low drops test mode |
| cmd_valid | input | 1 | One-cycle strobe for `cmd_word` |
| cmd_word | input | 16 | Decoded serial command word |
| strap_in | input | 4 | Strap pins; [1:0] must be low and [3:2] high for entry |
| test_mode | output | 1 | Latched test-mode flag |
| wdg_disable | output | 1 | Watchdog disable, high in test mode |
| cfg_vsel | output | 4 | Committed supply-voltage selection |
| cfg_ext_div | output | 1 | Committed external-divider select |
| cfg_bus_mode | output | 1 | Committed serial-bus mode select |
| cfg_locked | output | 1 | High once a configuration has been committed |
| prog_ok | output | 1 | One-cycle pulse: configuration write accepted |
| prog_rej | output | 1 | One-cycle pulse: configuration write discarded |

## Verification
Configuration writes are tried in four payload patterns. An even-parity payload with the lock bit set shows that parity is checked independently of the lock bit. An odd-parity payload with the lock bit clear shows the reverse. A fully valid payload must commit. A second valid payload after the commit separates the freeze from the validity checks. The entry word is also tried with a wrong strap pattern, and a near-miss word is tried with the correct straps, so that word matching and strap matching are each shown to be necessary. Configuration writes made before test mode is entered show that the write path is gated by the mode. Finally, a `pwr_good` drop followed by a reset shows which state survives which event.

// File: rtl/otp_cfg_pkg.sv
package otp_cfg_pkg;
  localparam int CMD_W   = 16;
  localparam int CFG_W   = 8;
  localparam int OP_W    = CMD_W - CFG_W;
  localparam int STRAP_N = 4;

  typedef struct packed {
    logic [3:0] vsel;
    logic       ext_div;
    logic       bus_mode;
    logic       par;
    logic       lock;
  } cfg_t;

  // odd parity over the whole byte and lock bit set
  function automatic logic cfg_byte_valid(input logic [CFG_W-1:0] b);
    return (^b) && b[0];
  endfunction

  function automatic logic [OP_W-1:0] cmd_opcode(input logic [CMD_W-1:0] w);
    return w[CMD_W-1:CFG_W];
  endfunction

  function automatic logic [CFG_W-1:0] cmd_payload(input logic [CMD_W-1:0] w);
    return w[CFG_W-1:0];
  endfunction
endpackage

// File: rtl/otp_strap_sampler.sv
module otp_strap_sampler #(
  parameter int               N   = 4,
  parameter logic [N-1:0]     PAT = 4'b1100
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] strap_in,
  output logic         match
);
  logic [N-1:0] strap_q;
  logic [N-1:0] bit_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strap_q <= '0;
    else        strap_q <= strap_in;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign bit_ok[i] = (strap_q[i] == PAT[i]);
  end

  assign match = &bit_ok;
endmodule

// File: rtl/otp_cmd_decode.sv
module otp_cmd_decode
  import otp_cfg_pkg::*;
#(
  parameter logic [CMD_W-1:0] ENTRY_CODE = 16'h5A5A,
  parameter logic [OP_W-1:0]  PROG_OP    = 8'hA9
) (
  input  logic             cmd_valid,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             is_entry,
  output logic             is_prog,
  output logic [CFG_W-1:0] prog_byte
);
  assign is_entry  = cmd_valid && (cmd_word == ENTRY_CODE);
  assign is_prog   = cmd_valid && (cmd_opcode(cmd_word) == PROG_OP);
  assign prog_byte = cmd_payload(cmd_word);
endmodule

// File: rtl/otp_test_latch.sv
module otp_test_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_good,
  input  logic enter_req,
  output logic test_mode
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         test_mode <= 1'b0;
    else if (!pwr_good) test_mode <= 1'b0;
    else if (enter_req) test_mode <= 1'b1;
  end

  // R1
  entry_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> $past(enter_req));

  // R2
  pwr_drop_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pwr_good |=> !test_mode);
endmodule

// File: rtl/otp_shadow_reg.sv
module otp_shadow_reg
  import otp_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prog_req,
  input  logic [CFG_W-1:0] prog_byte,
  output logic [3:0]       vsel,
  output logic             ext_div,
  output logic             bus_mode,
  output logic             locked,
  output logic             ok_pulse,
  output logic             rej_pulse
);
  cfg_t cfg_q;
  logic commit;
  logic discard;

  assign commit  = prog_req && !locked && cfg_byte_valid(prog_byte);
  assign discard = prog_req && !commit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      locked    <= 1'b0;
      ok_pulse  <= 1'b0;
      rej_pulse <= 1'b0;
    end else begin
      ok_pulse  <= commit;
      rej_pulse <= discard;
      if (commit) begin
        cfg_q  <= cfg_t'(prog_byte);
        locked <= 1'b1;
      end
    end
  end

  assign vsel     = cfg_q.vsel;
  assign ext_div  = cfg_q.ext_div;
  assign bus_mode = cfg_q.bus_mode;

  // R7
  frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> locked && $stable(cfg_q));

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok_pulse && rej_pulse));

  // R4
  ok_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_pulse |-> locked && $rose(locked));

  // R5
  ok_parity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ok_pulse |-> (^cfg_q) && cfg_q.lock);
endmodule

// File: rtl/otp_cfg_loader.sv
module otp_cfg_loader
  import otp_cfg_pkg::*;
#(
  parameter logic [CMD_W-1:0]   ENTRY_CODE = 16'h5A5A,
  parameter logic [OP_W-1:0]    PROG_OP    = 8'hA9,
  parameter logic [STRAP_N-1:0] STRAP_PAT  = 4'b1100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pwr_good,
  input  logic               cmd_valid,
  input  logic [CMD_W-1:0]   cmd_word,
  input  logic [STRAP_N-1:0] strap_in,
  output logic               test_mode,
  output logic               wdg_disable,
  output logic [3:0]         cfg_vsel,
  output logic               cfg_ext_div,
  output logic               cfg_bus_mode,
  output logic               cfg_locked,
  output logic               prog_ok,
  output logic               prog_rej
);
  logic             strap_match;
  logic             is_entry;
  logic             is_prog;
  logic [CFG_W-1:0] prog_byte;
  logic             enter_req;
  logic             prog_req;

  otp_strap_sampler #(.N(STRAP_N), .PAT(STRAP_PAT)) u_strap (
    .clk(clk), .rst_n(rst_n), .strap_in(strap_in), .match(strap_match)
  );

  otp_cmd_decode #(.ENTRY_CODE(ENTRY_CODE), .PROG_OP(PROG_OP)) u_dec (
    .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .is_entry(is_entry), .is_prog(is_prog), .prog_byte(prog_byte)
  );

  assign enter_req = is_entry && strap_match && pwr_good;

  otp_test_latch u_tm (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good),
    .enter_req(enter_req), .test_mode(test_mode)
  );

  assign prog_req    = is_prog && test_mode;
  assign wdg_disable = test_mode;

  otp_shadow_reg u_shadow (
    .clk(clk), .rst_n(rst_n), .prog_req(prog_req), .prog_byte(prog_byte),
    .vsel(cfg_vsel), .ext_div(cfg_ext_div), .bus_mode(cfg_bus_mode),
    .locked(cfg_locked), .ok_pulse(prog_ok), .rej_pulse(prog_rej)
  );

  // R8
  pulse_needs_tm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_ok || prog_rej) |-> $past(test_mode));

  // R3
  wdg_follows_tm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> wdg_disable);
endmodule

// File: tb/otp_cfg_loader_tb.sv
module otp_cfg_loader_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pwr_good = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [15:0] cmd_word = '0;
  logic [3:0]  strap_in = '0;
  logic        test_mode, wdg_disable, cfg_ext_div, cfg_bus_mode;
  logic        cfg_locked, prog_ok, prog_rej;
  logic [3:0]  cfg_vsel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  otp_cfg_loader u_dut (
    .clk(clk), .rst_n(rst_n), .pwr_good(pwr_good), .cmd_valid(cmd_valid),
    .cmd_word(cmd_word), .strap_in(strap_in), .test_mode(test_mode),
    .wdg_disable(wdg_disable), .cfg_vsel(cfg_vsel), .cfg_ext_div(cfg_ext_div),
    .cfg_bus_mode(cfg_bus_mode), .cfg_locked(cfg_locked),
    .prog_ok(prog_ok), .prog_rej(prog_rej)
  );

  // {strap, cmd, exp test_mode, exp ok, exp rej, exp cfg byte [7:2] in top bits, exp locked}
  localparam int NV = 9;
  localparam logic [31:0] VEC [0:NV-1] = '{
    {4'b1100, 16'hA9B3, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R8 write before test mode
    {4'b1101, 16'h5A5A, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R1 wrong strap
    {4'b1100, 16'h5A5B, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0},  // R1 wrong word
    {4'b1100, 16'h5A5A, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},  // R1 entry
    {4'b0000, 16'h1234, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0},  // R2 stays latched
    {4'b0000, 16'hA903, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},  // R5 even parity
    {4'b0000, 16'hA902, 1'b1, 1'b0, 1'b1, 8'h00, 1'b0},  // R6 lock clear
    {4'b0000, 16'hA9B3, 1'b1, 1'b1, 1'b0, 8'hB3, 1'b1},  // R4 commit
    {4'b0000, 16'hA931, 1'b1, 1'b0, 1'b1, 8'hB3, 1'b1}   // R7 frozen
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic send(input logic [15:0] w);
    cmd_word  = w;
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  function automatic logic [7:0] cfg_now();
    return {cfg_vsel, cfg_ext_div, cfg_bus_mode, 2'b00};
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    chk("R9 reset cfg", {8'h00, cfg_now()}, 16'h0000);
    chk("R9 reset lock/tm", {14'h0, cfg_locked, test_mode}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      strap_in = VEC[i][31:28];
      @(negedge clk);
      send(VEC[i][27:12]);
      chk($sformatf("R1/R2 row %0d test_mode", i), {15'h0, test_mode}, {15'h0, VEC[i][11]});
      chk($sformatf("R3 row %0d wdg", i), {15'h0, wdg_disable}, {15'h0, VEC[i][11]});
      chk($sformatf("R4-R8 row %0d pulses", i), {14'h0, prog_ok, prog_rej},
          {14'h0, VEC[i][10], VEC[i][9]});
      chk($sformatf("R4/R7 row %0d cfg", i), {8'h00, cfg_now()}, {8'h00, VEC[i][8:3] , 2'b00});
      chk($sformatf("R4 row %0d locked", i), {15'h0, cfg_locked}, {15'h0, VEC[i][0]});
    end

    // R10: pulse lasts one cycle
    @(negedge clk);
    chk("R10 pulse cleared", {14'h0, prog_ok, prog_rej}, 16'h0000);

    // R2/R9: power-good drop clears test mode, keeps config
    pwr_good = 1'b0;
    @(negedge clk);
    chk("R2 pwr drop clears tm", {15'h0, test_mode}, 16'h0000);
    chk("R3 wdg off", {15'h0, wdg_disable}, 16'h0000);
    chk("R9 cfg kept on pwr drop", {7'h0, cfg_locked, cfg_now()}, {7'h0, 1'b1, 8'hB0});
    // entry refused while power-good low
    strap_in = 4'b1100;
    @(negedge clk);
    send(16'h5A5A);
    chk("R1 no entry without pwr_good", {15'h0, test_mode}, 16'h0000);
    pwr_good = 1'b1;

    // R9: power-on reset clears config
    rst_n = 1'b0;
    @(negedge clk);
    chk("R9 reset clears cfg", {7'h0, cfg_locked, cfg_now()}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
    send(16'h5A5A);
    chk("R1 re-entry", {15'h0, test_mode}, 16'h0001);
    send(16'hA98F);
    chk("R4 commit 8F ok", {14'h0, prog_ok, prog_rej}, 16'h0002);
    chk("R4 fields 8F", {8'h00, cfg_now()}, {8'h00, 8'h8C});
    @(negedge clk);
    chk("R10 ok single cycle", {14'h0, prog_ok, prog_rej}, 16'h0000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule